// File: doc/BRIEF.md
# Dual Timer/Counter with Four Counting Modes

This block provides two independent event counters for a small controller subsystem. Each counter is held as a pair of byte registers: a low byte and a high byte. Each counter advances on one of two sources. The first is an internal tick that occurs once every `TICK_DIV` clocks. The second is a falling edge on its own count input pin. Counting is allowed by a run bit. When the gate option is selected, counting is further held off while the counter's gate pin is low.

A shared configuration byte selects one of four counting shapes for each counter:

- a 13-bit count, with a 5-bit prescaler below the high byte;
- a plain 16-bit count;
- an 8-bit count that refills itself from the high byte;
- a split arrangement, in which counter 0 becomes two separate 8-bit counters and counter 1 freezes.

When a counter wraps, it sets a flag in the control byte and drives a one-cycle pulse on an output. Downstream rate logic can use that pulse. All registers are read and written over a simple byte-wide bus. Reads are combinational and writes take effect at the clock edge.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register (control at address 0, configuration at 1, low byte 0 at 2, high byte 0 at 3, low byte 1 at 4, high byte 1 at 5) reads 0x00, and both overflow pulses are low.
- R2: When the source-select bit is 0 and the counter is running, the count advances by exactly one for every `TICK_DIV` (default 12) clocks. When the run bit is 0, the count does not change.
- R3: When the source-select bit is 1, the count advances once for each high-to-low transition of the count input pin. A rising edge or a steady level does not advance it.
- R4: When the gate bit is 1, counting also requires the gate pin to be high. With the gate pin low, input edges are ignored.
- R5: Shape 0 counts through 13 bits. Low-byte bits 4:0 form the bottom of the count and the high byte forms the top. Low-byte bits 7:5 are not changed by counting. A wrap from all ones to zero sets the flag.
- R6: Shape 1 counts through 16 bits, with the high byte above the low byte. A wrap from 0xFFFF to 0x0000 sets the flag.
- R7: In shape 2 only the low byte counts. When it wraps from 0xFF, it is loaded from the high byte, the high byte is unchanged, and the flag is set.
- R8: In shape 3, the low byte of counter 0 counts from counter 0's own source, run bit and gate, and sets flag 0. The high byte of counter 0 counts internal ticks whenever run bit 1 is set, and its wrap sets flag 1 without pulsing overflow output 1.
- R9: Counter 1 in shape 3 holds its value regardless of its run bit and source.
- R10: The control byte holds flag 1 at bit 7, run 1 at bit 6, flag 0 at bit 5 and run 0 at bit 4. Its bits 3:0 are plain storage. A wrap sets the counter's flag and pulses its overflow output for exactly one cycle. A flag set by a wrap takes precedence over a bus write in the same cycle.
- R11: A bus write to a count byte in the same cycle as an increment leaves the written value in that byte.
- R12: The configuration byte holds counter 1 in bits 7:4 and counter 0 in bits 3:0. Each nibble is laid out, from high to low, as gate, source-select and a 2-bit shape. Both the configuration byte and the control byte read back the value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| cntIn0 | input | 1 | Count input pin, counter 0 |
| cntIn1 | input | 1 | Count input pin, counter 1 |
| gateIn0 | input | 1 | Gate pin, counter 0 |
| gateIn1 | input | 1 | Gate pin, counter 1 |
| ovfPulse0 | output | 1 | One-cycle wrap pulse, counter 0 |
| ovfPulse1 | output | 1 | One-cycle wrap pulse, counter 1 |

## Verification
Two collisions are the hardest cases to reach from the ports: a bus write landing in the same clock as a tick-driven increment, and a software flag clear landing in the same clock as a wrap. The tick phase cannot be seen from outside the block. The stimulus therefore holds the write strobe for twelve consecutive clocks, reading back after every edge, so that exactly one of those edges must carry a tick. For the flag race, counter 0 is set up in the refill shape with a refill value of 0xFF, so that every tick wraps. Under continuous clear writes, exactly one of the twelve readbacks must then show the flag set. Edge-driven tests use the count pins so that expected counts do not depend on the tick phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd5;

  localparam int B_FLAG1 = 7;
  localparam int B_RUN1  = 6;
  localparam int B_FLAG0 = 5;
  localparam int B_RUN0  = 4;

  typedef enum logic [1:0] {
    SHAPE_13     = 2'd0,
    SHAPE_16     = 2'd1,
    SHAPE_REFILL = 2'd2,
    SHAPE_SPLIT  = 2'd3
  } shape_e;

  typedef struct packed {
    logic   gate;
    logic   extSrc;
    shape_e shape;
  } cfgNib_t;

  typedef struct packed {
    logic step0;
    logic step1;
    logic stepHi0;
  } strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int TICK_DIV    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgNib_t [1:0]     cfg,
  input  logic    [1:0]     run,
  input  logic    [1:0]     extPin,
  input  logic    [1:0]     gatePin,
  output strobe_t           strobes
);
  localparam int PW = $clog2(TICK_DIV);

  logic [PW-1:0] divCnt;
  logic          tick;
  logic [1:0]    fallEvt;
  logic [1:0]    gateLvl;
  logic [1:0]    srcEvt;
  logic [1:0]    allow;

  assign tick = (divCnt == PW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + PW'(1);
  end

  for (genvar i = 0; i < 2; i++) begin : g_pin
    logic [SYNC_STAGES:0]   extSh;
    logic [SYNC_STAGES-1:0] gateSh;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        extSh  <= '0;
        gateSh <= '0;
      end else begin
        extSh  <= {extSh[SYNC_STAGES-1:0], extPin[i]};
        gateSh <= {gateSh[SYNC_STAGES-2:0], gatePin[i]};
      end
    end
    assign fallEvt[i] = extSh[SYNC_STAGES] & ~extSh[SYNC_STAGES-1];
    assign gateLvl[i] = gateSh[SYNC_STAGES-1];
    assign srcEvt[i]  = cfg[i].extSrc ? fallEvt[i] : tick;
    assign allow[i]   = run[i] & (~cfg[i].gate | gateLvl[i]);
  end

  assign strobes.step0   = allow[0] & srcEvt[0];
  assign strobes.step1   = allow[1] & srcEvt[1] & (cfg[1].shape != SHAPE_SPLIT);
  assign strobes.stepHi0 = tick & run[1] & (cfg[0].shape == SHAPE_SPLIT);

  AST_EDGE_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfg[0].extSrc && strobes.step0) |=> !(cfg[0].extSrc && strobes.step0)); // R3
endmodule

// File: rtl/tmr_data.sv
module tmr_data
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BYTE_W-1:0]   busWdata,
  output logic [BYTE_W-1:0]   busRdata,
  input  strobe_t             strobes,
  output cfgNib_t [1:0]       cfg,
  output logic    [1:0]       run,
  output logic    [1:0]       ovfPulse
);
  localparam int CW = 2 * BYTE_W + 1;

  logic [BYTE_W-1:0]       ctrlReg, cfgReg;
  logic [1:0][BYTE_W-1:0]  lo, hi;
  logic [1:0][BYTE_W-1:0]  loNxt, hiNxt;
  logic [BYTE_W-1:0]       ctrlNxt;
  logic [1:0]              wrap;
  logic                    wrapHi0;
  logic                    wrLo0, wrHi0, wrLo1, wrHi1, wrCtrl, wrCfg;

  assign wrCtrl = busWe && busAddr == A_CTRL;
  assign wrCfg  = busWe && busAddr == A_CFG;
  assign wrLo0  = busWe && busAddr == A_LO0;
  assign wrHi0  = busWe && busAddr == A_HI0;
  assign wrLo1  = busWe && busAddr == A_LO1;
  assign wrHi1  = busWe && busAddr == A_HI1;

  assign cfg = cfgReg;
  assign run = {ctrlReg[B_RUN1], ctrlReg[B_RUN0]};

  function automatic logic [CW-1:0] advance(input shape_e m,
                                            input logic [BYTE_W-1:0] h,
                                            input logic [BYTE_W-1:0] l);
    logic [BYTE_W+PRE_W:0] s13;
    logic [CW-1:0]         s16;
    logic [BYTE_W:0]       s8;
    s13 = {1'b0, h, l[PRE_W-1:0]} + (BYTE_W+PRE_W+1)'(1);
    s16 = {1'b0, h, l} + CW'(1);
    s8  = {1'b0, l} + (BYTE_W+1)'(1);
    case (m)
      SHAPE_13:     advance = {s13[BYTE_W+PRE_W], s13[BYTE_W+PRE_W-1:PRE_W],
                               l[BYTE_W-1:PRE_W], s13[PRE_W-1:0]};
      SHAPE_16:     advance = s16;
      SHAPE_REFILL: advance = s8[BYTE_W] ? {1'b1, h, h} : {1'b0, h, s8[BYTE_W-1:0]};
      default:      advance = {s8[BYTE_W], h, s8[BYTE_W-1:0]};
    endcase
  endfunction

  always_comb begin
    loNxt   = lo;
    hiNxt   = hi;
    wrap    = '0;
    wrapHi0 = 1'b0;
    if (strobes.step0)
      {wrap[0], hiNxt[0], loNxt[0]} = advance(cfg[0].shape, hi[0], lo[0]);
    if (strobes.stepHi0)
      {wrapHi0, hiNxt[0]} = {1'b0, hi[0]} + (BYTE_W+1)'(1);
    if (strobes.step1)
      {wrap[1], hiNxt[1], loNxt[1]} = advance(cfg[1].shape, hi[1], lo[1]);
    if (wrLo0) loNxt[0] = busWdata;
    if (wrHi0) hiNxt[0] = busWdata;
    if (wrLo1) loNxt[1] = busWdata;
    if (wrHi1) hiNxt[1] = busWdata;
    ctrlNxt = wrCtrl ? busWdata : ctrlReg;
    if (wrap[0])           ctrlNxt[B_FLAG0] = 1'b1;
    if (wrap[1] | wrapHi0) ctrlNxt[B_FLAG1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      cfgReg   <= '0;
      lo       <= '0;
      hi       <= '0;
      ovfPulse <= '0;
    end else begin
      ctrlReg  <= ctrlNxt;
      if (wrCfg) cfgReg <= busWdata;
      lo       <= loNxt;
      hi       <= hiNxt;
      ovfPulse <= wrap;
    end
  end

  always_comb begin
    case (busAddr)
      A_CTRL:  busRdata = ctrlReg;
      A_CFG:   busRdata = cfgReg;
      A_LO0:   busRdata = lo[0];
      A_HI0:   busRdata = hi[0];
      A_LO1:   busRdata = lo[1];
      A_HI1:   busRdata = hi[1];
      default: busRdata = '0;
    endcase
  end

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[B_RUN0] && cfg[0].shape != SHAPE_SPLIT && !wrLo0 && !wrHi0)
      |=> $stable({hi[0], lo[0]})); // R2
  AST_REFILL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (cfg[0].shape == SHAPE_REFILL && strobes.step0 && lo[0] == '1 && !wrLo0 && !wrHi0)
      |=> lo[0] == $past(hi[0])); // R7
  AST_SPLIT_T1_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (cfg[1].shape == SHAPE_SPLIT && !wrLo1 && !wrHi1) |=> $stable({hi[1], lo[1]})); // R9
  AST_PULSE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse[0] |-> ctrlReg[B_FLAG0]); // R10
  AST_WRITE_BEATS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    wrLo0 |=> lo[0] == $past(busWdata)); // R11
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int TICK_DIV    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       cntIn0,
  input  logic       cntIn1,
  input  logic       gateIn0,
  input  logic       gateIn1,
  output logic       ovfPulse0,
  output logic       ovfPulse1
);
  strobe_t       strobes;
  cfgNib_t [1:0] cfg;
  logic    [1:0] run;
  logic    [1:0] ovfPulse;

  tmr_ctrl #(.TICK_DIV(TICK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfg),
    .run     (run),
    .extPin  ({cntIn1, cntIn0}),
    .gatePin ({gateIn1, gateIn0}),
    .strobes (strobes)
  );

  tmr_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .strobes  (strobes),
    .cfg      (cfg),
    .run      (run),
    .ovfPulse (ovfPulse)
  );

  assign ovfPulse0 = ovfPulse[0];
  assign ovfPulse1 = ovfPulse[1];
endmodule

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       cntIn0 = 1'b1, cntIn1 = 1'b1;
  logic       gateIn0 = 1'b0, gateIn1 = 1'b0;
  logic       ovfPulse0, ovfPulse1;

  int nChecks = 0;
  int nFails = 0;
  int pulses0 = 0;
  int pulses1 = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_pair u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cntIn0(cntIn0), .cntIn1(cntIn1),
    .gateIn0(gateIn0), .gateIn1(gateIn1), .ovfPulse0(ovfPulse0), .ovfPulse1(ovfPulse1)
  );

  always @(negedge clk) if (rstN) begin
    if (ovfPulse0) pulses0++;
    if (ovfPulse1) pulses1++;
  end

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic fallPulse(input int idx);
    @(negedge clk);
    if (idx == 0) cntIn0 = 1'b0; else cntIn1 = 1'b0;
    repeat (5) @(negedge clk);
    if (idx == 0) cntIn0 = 1'b1; else cntIn1 = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reg %0d after reset", a), d, 0);
    end
    check("R1 pulse0 low", ovfPulse0, 0);
    check("R1 pulse1 low", ovfPulse1, 0);
  endtask

  task automatic testReadback();
    logic [7:0] d;
    wr(3'd1, 8'hA5); rd(3'd1, d); check("R12 cfg readback", d, 8'hA5);
    wr(3'd0, 8'h0F); rd(3'd0, d); check("R12 ctrl readback", d, 8'h0F);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
  endtask

  task automatic testTimerRate();
    logic [7:0] a, b;
    wr(3'd0, 8'h00); wr(3'd1, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    repeat (30) @(negedge clk);
    rd(3'd2, a); check("R2 stopped count", a, 0);
    wr(3'd0, 8'h10);
    rd(3'd2, a);
    repeat (119) @(negedge clk);
    rd(3'd2, b);
    check("R2 ticks per 120 clocks", b - a, 10);
  endtask

  task automatic testEdges();
    logic [7:0] d;
    wr(3'd0, 8'h00); wr(3'd1, 8'h05); wr(3'd2, 8'h10); wr(3'd3, 8'h00); wr(3'd0, 8'h10);
    @(negedge clk); cntIn0 = 1'b0;
    repeat (10) @(negedge clk);
    rd(3'd2, d); check("R3 one step per fall", d, 8'h11);
    cntIn0 = 1'b1;
    repeat (10) @(negedge clk);
    rd(3'd2, d); check("R3 rise ignored", d, 8'h11);
  endtask

  task automatic testGate();
    logic [7:0] d;
    wr(3'd0, 8'h00); wr(3'd1, 8'h0D); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h10);
    gateIn0 = 1'b0; repeat (4) @(negedge clk);
    fallPulse(0);
    rd(3'd2, d); check("R4 gate low blocks", d, 0);
    gateIn0 = 1'b1; repeat (4) @(negedge clk);
    fallPulse(0);
    rd(3'd2, d); check("R4 gate high counts", d, 1);
    gateIn0 = 1'b0;
  endtask

  task automatic testShape16();
    logic [7:0] d;
    int p;
    wr(3'd0, 8'h00); wr(3'd1, 8'h05); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd0, 8'h10);
    fallPulse(0);
    rd(3'd2, d); check("R6 low to FF", d, 8'hFF);
    rd(3'd0, d); check("R6 no flag yet", d, 8'h10);
    p = pulses0;
    fallPulse(0);
    rd(3'd2, d); check("R6 low wraps", d, 0);
    rd(3'd3, d); check("R6 high wraps", d, 0);
    rd(3'd0, d); check("R10 flag0 set", d, 8'h30);
    check("R10 one pulse", pulses0 - p, 1);
  endtask

  task automatic testShape13();
    logic [7:0] d;
    wr(3'd0, 8'h00); wr(3'd1, 8'h04); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, 8'h10);
    fallPulse(0);
    rd(3'd2, d); check("R5 low keeps 7:5", d, 8'hE0);
    rd(3'd3, d); check("R5 high wraps", d, 0);
    rd(3'd0, d); check("R5 flag0", d, 8'h30);
    wr(3'd0, 8'h00); wr(3'd2, 8'h1F); wr(3'd3, 8'h12); wr(3'd0, 8'h10);
    fallPulse(0);
    rd(3'd2, d); check("R5 prescaler carry low", d, 0);
    rd(3'd3, d); check("R5 prescaler carry high", d, 8'h13);
  endtask

  task automatic testRefill();
    logic [7:0] d;
    wr(3'd0, 8'h00); wr(3'd1, 8'h06); wr(3'd3, 8'h80); wr(3'd2, 8'hFE); wr(3'd0, 8'h10);
    fallPulse(0);
    rd(3'd2, d); check("R7 low steps", d, 8'hFF);
    fallPulse(0);
    rd(3'd2, d); check("R7 refilled", d, 8'h80);
    rd(3'd3, d); check("R7 high kept", d, 8'h80);
    rd(3'd0, d); check("R7 flag0", d, 8'h30);
  endtask

  task automatic testSplit();
    logic [7:0] d;
    int p;
    wr(3'd0, 8'h00); wr(3'd1, 8'h07); wr(3'd2, 8'hFF); wr(3'd3, 8'hF0); wr(3'd0, 8'h10);
    fallPulse(0);
    rd(3'd2, d); check("R8 low half wraps", d, 0);
    rd(3'd0, d); check("R8 low half sets flag0", d, 8'h30);
    repeat (200) @(negedge clk);
    rd(3'd3, d); check("R8 high half idle without run1", d, 8'hF0);
    p = pulses1;
    wr(3'd0, 8'h40);
    repeat (250) @(negedge clk);
    rd(3'd0, d); check("R8 high half sets flag1", d, 8'hC0);
    rd(3'd2, d); check("R8 low half idle without run0", d, 0);
    check("R8 no pulse1 from high half", pulses1 - p, 0);
  endtask

  task automatic testT1Frozen();
    logic [7:0] d;
    wr(3'd0, 8'h00); wr(3'd1, 8'h30); wr(3'd4, 8'h55); wr(3'd5, 8'hAA); wr(3'd0, 8'h40);
    repeat (150) @(negedge clk);
    rd(3'd4, d); check("R9 low1 held", d, 8'h55);
    rd(3'd5, d); check("R9 high1 held", d, 8'hAA);
    wr(3'd1, 8'h70);
    fallPulse(1); fallPulse(1);
    rd(3'd4, d); check("R9 low1 held on edges", d, 8'h55);
  endtask

  task automatic testWriteWins();
    int bad = 0;
    wr(3'd0, 8'h00); wr(3'd1, 8'h01); wr(3'd0, 8'h10);
    @(negedge clk);
    busWe = 1'b1; busAddr = 3'd2; busWdata = 8'h40;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      #1 if (busRdata !== 8'h40) bad++;
    end
    busWe = 1'b0;
    check("R11 write wins over step", bad, 0);
  endtask

  task automatic testFlagRace();
    int seen = 0;
    int p;
    wr(3'd0, 8'h00); wr(3'd1, 8'h02); wr(3'd3, 8'hFF); wr(3'd2, 8'hFF); wr(3'd0, 8'h10);
    @(negedge clk);
    busWe = 1'b1; busAddr = 3'd0; busWdata = 8'h10;
    #1 p = pulses0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      #1 if (busRdata[5]) seen++;
    end
    busWe = 1'b0;
    check("R10 set beats clear", seen, 1);
    check("R10 pulse per wrap", pulses0 - p, 1);
  endtask

  task automatic finishRun();
    if (done) return;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadback();
    testTimerRate();
    testEdges();
    testGate();
    testShape16();
    testShape13();
    testRefill();
    testSplit();
    testT1Frozen();
    testWriteWins();
    testFlagRace();
    finishRun();
  end
endmodule